// File: doc/BRIEF.md
# Write enable and block protection unit

This unit is the write-permission core of a small serial memory. It holds the write-enable latch and the two block-protect bits, and it forms the status byte that a status read returns. It also decides, for each write attempt, whether the attempt may proceed. A serial front end feeds it decoded events: a completed instruction byte, any further bit clocked after that byte, and the chip-select rise that closes a frame. The front end also supplies qualified commit strobes for array writes and status writes, the target address of an array write, and the new protect field of a status write. The write engine reports its self-timed busy period back to the unit.

The unit grants an array write only when the write-protect pin is high, the latch is set, no write is running, and the address lies outside the protected range. A status write needs the same conditions except the range check. A granted commit clears the latch. A granted status write does not change the protect bits straight away. It stores the new value and applies it when the busy period that follows ends. A pin drop during that period therefore cannot cancel it. The protect bits survive a soft reset. Only the power-on reset loads them from a parameter.

Top module: `wr_guard`

## Requirements
- R1: The status byte reads zero in bits 7..4, the protect field in bits 3..2, the latch in bit 1 and the busy input in bit 0.
- R2: An instruction byte of 8'h06 sets the latch on the next frame close. This holds only when no further bit arrived between the byte and the close. A further bit cancels the pending set.
- R3: An instruction byte of 8'h04 clears the latch.
- R4: While wp_n is low, the latch is cleared every cycle and both permits are low.
- R5: The protect field selects which array addresses are refused: 0 refuses none, 1 refuses the top quarter (0x180 and up with 9 address bits), 2 refuses the top half (0x100 and up), and 3 refuses every address.
- R6: sr_wr_ok is high exactly when wp_n is high, the latch is set and busy is low.
- R7: A granted commit (arr_go or sr_go) clears the latch in the next cycle. A refused commit leaves the latch unchanged.
- R8: A granted status write loads sr_bp_wr into the protect field in the cycle after busy next falls. Until then the field keeps its old value, and wp_n going low in the meantime does not stop the load.
- R9: srst_n low clears the latch and leaves the protect field unchanged. por_n low clears the latch and loads the protect field with BP_INIT.
- R10: While busy is high, no commit is granted and the latch is left as it was.
- R11: When a qualified write-enable frame close falls in the same cycle as wp_n low, the latch stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| srst_n | input | 1 | Soft reset, active low, keeps protect bits |
| wp_n | input | 1 | Write-protect pin, low protects |
| busy | input | 1 | Self-timed write in progress |
| op_vld | input | 1 | Instruction byte complete this cycle |
| op_code | input | 8 | Instruction byte |
| more_bit | input | 1 | A bit was clocked in after the instruction byte |
| frame_end | input | 1 | Chip select rose this cycle |
| wr_commit | input | 1 | Array write frame closed correctly |
| wr_addr | input | ADDR_W | Array write address |
| sr_commit | input | 1 | Status write frame closed correctly |
| sr_bp_wr | input | 2 | New protect field carried by the status write |
| status | output | 8 | Status byte |
| arr_wr_ok | output | 1 | Array write at wr_addr would be granted |
| sr_wr_ok | output | 1 | Status write would be granted |
| arr_go | output | 1 | Array commit granted this cycle |
| sr_go | output | 1 | Status commit granted this cycle |

## Verification
The latch update has several causes, and two of them can fall on the same clock. The case of interest is a qualified write-enable frame close arriving in the very cycle the protect pin is low. The bench provokes it by holding wp_n low only in that cycle. It judges the result by reading status bit 1 afterwards, which must stay clear. The bench also lands a granted status write in the cycle where an earlier busy period ends. It then checks that the old pending value is applied and the new one stays pending.

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int         ADDR_W   = 9,
  parameter logic [1:0] BP_INIT  = 2'b00,
  parameter logic [7:0] OP_SETWE = 8'h06,
  parameter logic [7:0] OP_CLRWE = 8'h04
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              srst_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              op_vld,
  input  logic [7:0]        op_code,
  input  logic              more_bit,
  input  logic              frame_end,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              sr_commit,
  input  logic [1:0]        sr_bp_wr,
  output logic [7:0]        status,
  output logic              arr_wr_ok,
  output logic              sr_wr_ok,
  output logic              arr_go,
  output logic              sr_go
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [AW1-1:0] DEPTH  = AW1'(1) << ADDR_W;
  localparam logic [AW1-1:0] HALF   = DEPTH >> 1;
  localparam logic [AW1-1:0] QUART3 = HALF + (DEPTH >> 2);

  logic       wel, wren_arm, bp_pend, busy_q;
  logic [1:0] bp, bp_next;
  logic [AW1-1:0] lo_bound;
  logic       in_prot, busy_fell;

  always_comb begin
    unique case (bp)
      2'd1:    lo_bound = QUART3;
      2'd2:    lo_bound = HALF;
      default: lo_bound = '0;
    endcase
  end

  assign in_prot   = (bp != 2'd0) && ({1'b0, wr_addr} >= lo_bound);
  assign busy_fell = busy_q & ~busy;
  assign sr_wr_ok  = wp_n & wel & ~busy;
  assign arr_wr_ok = sr_wr_ok & ~in_prot;
  assign arr_go    = wr_commit & arr_wr_ok;
  assign sr_go     = sr_commit & sr_wr_ok;
  assign status    = {4'b0000, bp, wel, busy};

  always_ff @(posedge clk) begin
    if (!por_n) begin
      bp      <= BP_INIT;
      bp_next <= 2'b00;
      bp_pend <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy_fell && bp_pend) begin
        bp      <= bp_next;
        bp_pend <= 1'b0;
      end
      if (sr_go) begin
        bp_pend <= 1'b1;
        bp_next <= sr_bp_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !srst_n) begin
      wel      <= 1'b0;
      wren_arm <= 1'b0;
    end else begin
      if (frame_end || more_bit) wren_arm <= 1'b0;
      else if (op_vld)           wren_arm <= (op_code == OP_SETWE);

      if (!wp_n)                                wel <= 1'b0;
      else if (arr_go || sr_go)                 wel <= 1'b0;
      else if (op_vld && op_code == OP_CLRWE)   wel <= 1'b0;
      else if (frame_end && wren_arm)           wel <= 1'b1;
    end
  end
endmodule

module wr_guard_chk (
  input logic clk,
  input logic por_n,
  input logic srst_n,
  input logic wp_n,
  input logic busy,
  input logic frame_end,
  input logic wel,
  input logic arr_go,
  input logic sr_go
);
  // R4
  wp_low_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    !wp_n |=> !wel);
  // R7
  go_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    (arr_go || sr_go) |=> !wel);
  // R2
  wel_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wel) |-> $past(frame_end));
  // R10
  busy_no_go_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !(arr_go || sr_go));
  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    !srst_n |=> !wel);
  // R6
  go_needs_wel_chk: assert property (@(posedge clk) disable iff (!por_n)
    (arr_go || sr_go) |-> (wp_n && wel));
endmodule

bind wr_guard wr_guard_chk chk_i (
  .clk(clk), .por_n(por_n), .srst_n(srst_n), .wp_n(wp_n), .busy(busy),
  .frame_end(frame_end), .wel(status[1]), .arr_go(arr_go), .sr_go(sr_go)
);

// File: tb/wr_guard_tb.sv
module wr_guard_tb_top;
  localparam logic [1:0] BPI = 2'b01;
  logic clk = 1'b0;
  logic por_n = 1'b0, srst_n = 1'b1, wp_n = 1'b1, busy = 1'b0;
  logic op_vld = 1'b0, more_bit = 1'b0, frame_end = 1'b0;
  logic wr_commit = 1'b0, sr_commit = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [8:0] wr_addr = 9'h000;
  logic [1:0] sr_bp_wr = 2'b00;
  logic [7:0] status;
  logic arr_wr_ok, sr_wr_ok, arr_go, sr_go;

  int checks = 0, errors = 0;
  bit done = 0;

  wr_guard #(.ADDR_W(9), .BP_INIT(BPI)) dut_i (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .wp_n(wp_n), .busy(busy),
    .op_vld(op_vld), .op_code(op_code), .more_bit(more_bit),
    .frame_end(frame_end), .wr_commit(wr_commit), .wr_addr(wr_addr),
    .sr_commit(sr_commit), .sr_bp_wr(sr_bp_wr), .status(status),
    .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok), .arr_go(arr_go), .sr_go(sr_go)
  );

  always #5 clk = ~clk;

  // behavioural reference
  bit m_wel, m_arm, m_pend, m_busy_q, ag, sg, fell, old_arm;
  logic [1:0] m_bp, m_bpn;

  function automatic bit m_sr_ok();
    return wp_n && m_wel && !busy;
  endfunction
  function automatic bit m_arr_ok();
    int a = int'(wr_addr);
    bit refused = (m_bp == 2'd3) || (m_bp == 2'd2 && a >= 256) || (m_bp == 2'd1 && a >= 384);
    return m_sr_ok() && !refused;
  endfunction

  always @(posedge clk) begin
    fell = m_busy_q && !busy;
    if (!por_n) begin
      m_wel = 0; m_arm = 0; m_bp = BPI; m_pend = 0; m_bpn = 0; m_busy_q = 0;
    end else begin
      ag = wr_commit && m_arr_ok();
      sg = sr_commit && m_sr_ok();
      m_busy_q = busy;
      if (fell && m_pend) begin m_bp = m_bpn; m_pend = 0; end
      if (sg) begin m_pend = 1; m_bpn = sr_bp_wr; end
      if (!srst_n) begin m_wel = 0; m_arm = 0; end
      else begin
        old_arm = m_arm;
        if (frame_end || more_bit) m_arm = 0;
        else if (op_vld) m_arm = (op_code == 8'h06);
        if (!wp_n) m_wel = 0;
        else if (ag || sg) m_wel = 0;
        else if (op_vld && op_code == 8'h04) m_wel = 0;
        else if (frame_end && old_arm) m_wel = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    #2;
    chk(status == {4'b0, m_bp, m_wel, busy}, "R1 status", status, {4'b0, m_bp, m_wel, busy});
    chk(arr_wr_ok == m_arr_ok(), "R5 arr_wr_ok", arr_wr_ok, m_arr_ok());
    chk(sr_wr_ok == m_sr_ok(), "R6 sr_wr_ok", sr_wr_ok, m_sr_ok());
    chk(arr_go == (wr_commit && m_arr_ok()), "R7 arr_go", arr_go, wr_commit && m_arr_ok());
    chk(sr_go == (sr_commit && m_sr_ok()), "R8 sr_go", sr_go, sr_commit && m_sr_ok());
    @(negedge clk);
    op_vld = 0; more_bit = 0; frame_end = 0; wr_commit = 0; sr_commit = 0;
  endtask

  task automatic see(input string tag, input int act, input int exp);
    #1; chk(act == exp, tag, act, exp);
  endtask

  task automatic send_op(input logic [7:0] op);
    op_vld = 1; op_code = op; tick();
  endtask
  task automatic close(); frame_end = 1; tick(); endtask
  task automatic wren(); send_op(8'h06); close(); endtask
  task automatic wrsr(input logic [1:0] v);
    wren(); sr_bp_wr = v; sr_commit = 1; tick();
    busy = 1; repeat (3) tick(); busy = 0; tick();
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    see("R9 por state", status, 8'h04);
    por_n = 1; tick();
    wren(); see("R2 wren sets", status[1], 1);
    send_op(8'h04); see("R3 wrdi clears", status[1], 0);
    send_op(8'h06); more_bit = 1; tick(); close();
    see("R2 extra bit cancels", status[1], 0);
    wren(); wr_addr = 9'h17F; wr_commit = 1; #1;
    chk(arr_go == 1, "R5 below quarter granted", arr_go, 1);
    tick(); see("R7 granted clears", status[1], 0);
    wren(); wr_addr = 9'h180; wr_commit = 1; #1;
    chk(arr_go == 0, "R5 top quarter refused", arr_go, 0);
    tick(); see("R7 refused keeps", status[1], 1);
    wr_addr = 9'h000;
    wren(); sr_bp_wr = 2'd3; sr_commit = 1; tick();
    busy = 1; tick();
    see("R1 busy bit", status[0], 1);
    wp_n = 0; tick(); wp_n = 1; tick();
    see("R8 old bp while busy", status[3:2], 2'd1);
    busy = 0; tick();
    see("R8 bp applied", status[3:2], 2'd3);
    wren(); #1; chk(arr_wr_ok == 0, "R5 all refused", arr_wr_ok, 0);
    wrsr(2'd2);
    wren(); wr_addr = 9'h0FF; #1; chk(arr_wr_ok == 1, "R5 half low ok", arr_wr_ok, 1);
    wr_addr = 9'h100; #1; chk(arr_wr_ok == 0, "R5 half high refused", arr_wr_ok, 0);
    tick();
    wrsr(2'd0);
    wren(); wr_addr = 9'h1FF; #1; chk(arr_wr_ok == 1, "R5 none refused", arr_wr_ok, 1);
    busy = 1; wr_commit = 1; #1;
    chk(arr_go == 0, "R10 busy blocks", arr_go, 0);
    tick(); busy = 0;
    see("R10 wel kept", status[1], 1);
    wp_n = 0; tick(); see("R4 wp low clears", status[1], 0);
    chk(sr_wr_ok == 0, "R4 permit low", sr_wr_ok, 0);
    wp_n = 1;
    send_op(8'h06); wp_n = 0; frame_end = 1; tick(); wp_n = 1;
    see("R11 wp wins over wren", status[1], 0);
    // granted status write coinciding with end of previous busy
    wren(); sr_bp_wr = 2'd1; sr_commit = 1; tick();
    busy = 1; tick(); wren();
    busy = 0; sr_bp_wr = 2'd2; sr_commit = 1; tick();
    see("R8 first value applied", status[3:2], 2'd1);
    busy = 1; tick(); busy = 0; tick();
    see("R8 second value applied", status[3:2], 2'd2);
    wren(); srst_n = 0; tick(); srst_n = 1;
    see("R9 soft reset clears wel", status[1], 0);
    see("R9 soft reset keeps bp", status[3:2], 2'd2);
    por_n = 0; tick(); por_n = 1; tick();
    see("R9 hard reset bp", status[3:2], BPI);
    repeat (3) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule